// File: doc/BRIEF.md
# Clock Source Select with Oscillator Ready Flags

This block holds one control and status byte that picks which oscillator drives the system clock. Two sticky ready flags report whether each oscillator has finished starting up. The main oscillator has a startup counter that counts main-oscillator ticks while the oscillator is enabled. The auxiliary crystal oscillator has one that counts timebase ticks. Each flag goes high when its counter reaches its terminal count.

The flags belong to the power-on domain. Only the power-on detect input clears them, and an ordinary system reset leaves them as they are. The main flag also drops when software disables the main oscillator. The select, enable and option bits belong to the ordinary reset domain. Both reset inputs are asserted asynchronously and are released two clock edges after they go high.

The block enforces the rule that the clock may only be switched to an oscillator that is ready. If a write asks for a source whose ready flag is clear, the select bits keep their old value. The other writable bits in the same write still take effect. The clock multiplexer and the oscillators themselves lie outside the block.

Top module: `clk_src_ctl`

## Requirements
- R1: While system reset or power-on detect is active, and for two clock edges after release, the writable bits read as select 2'b10, enable 1 and option 0. clk_sel_o is 2'b10 and osc_en_o is 1.
- R2: Power-on detect clears both ready flags (bit 7 main, bit 6 auxiliary) and both startup counters.
- R3: Ordinary system reset with power-on detect inactive leaves both ready flags and both counters unchanged.
- R4: The auxiliary flag rises on the clock edge that samples the AUX_COUNT-th timebase tick after power-on release. It then stays set, and further ticks do not change it.
- R5: The main flag rises on the edge that samples the MAIN_COUNT-th main tick counted while the enable bit is 1.
- R6: One edge after the enable bit reads 0, the main flag reads 0 and the main counter is zero. Counting restarts from zero once the enable bit is set again.
- R7: Bits 5 and 4 always read 0. The flag bits are read-only, and write data exists only for bits 3..0.
- R8: On a write, select value 2'b11 (auxiliary) is taken only if the auxiliary flag is set. Values 2'b00, 2'b01 and 2'b10 (main) are taken only if the main flag is set. A write whose select is refused leaves the select unchanged.
- R9: The enable bit (bit 1) and the option bit (bit 0) take the write data on every write, whether or not the select is taken. clk_sel_o mirrors bits 3..2 and osc_en_o mirrors bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Ordinary system reset, active low |
| por_n | input | 1 | Power-on detect, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 4 | Write data for bits 3..0 |
| xtick_i | input | 1 | Timebase tick from the auxiliary oscillator |
| mtick_i | input | 1 | Main-oscillator tick |
| rdata_o | output | 8 | Register read value |
| osc_en_o | output | 1 | Main oscillator enable |
| clk_sel_o | output | 2 | System clock source select |

## Verification
The assertions take for granted that the tick and write inputs change only between clock edges. They also assume the reset inputs go high only after a stretch of clock activity. Under those conditions, a flag can rise only on an edge that sampled a tick, and a refused write can be judged from the flag values before the edge. The stimulus drives every input on the falling edge. It holds each reset for several cycles. It runs the ticks at fixed or sparse rates, so that flag rises, refused writes and enable toggles each happen on a known edge.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  // Writable field layout, bits 3..0 of the register
  typedef struct packed {
    logic [1:0] sel;
    logic       en;
    logic       opt;
  } ctl_t;

  localparam int        CTL_W   = 4;
  localparam logic [1:0] SEL_AUX = 2'b11;
  localparam ctl_t       CTL_RST = '{sel: 2'b10, en: 1'b1, opt: 1'b0};

endpackage

// File: rtl/clk_src_rst_sync.sv
module clk_src_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/clk_src_startup.sv
module clk_src_startup #(
  parameter int COUNT = 1024
) (
  input  logic clk,
  input  logic arst_n_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic rdy_o
);

  localparam int            CW   = $clog2(COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);
  localparam logic [CW-1:0] TERM = CW'(COUNT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic          cnt_ce;

  assign cnt_ce = tick_i && !rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (clr_i) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (cnt_ce) begin
      if (cnt_q == LAST) begin
        cnt_d = TERM;
        rdy_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_o = rdy_q;

endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_src_pkg::*;
#(
  parameter int AUX_COUNT   = 8072,
  parameter int MAIN_COUNT  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             xtick_i,
  input  logic             mtick_i,
  output logic [7:0]       rdata_o,
  output logic             osc_en_o,
  output logic [1:0]       clk_sel_o
);

  logic por_sync_n, ctl_sync_n;
  logic aux_rdy, main_rdy;
  logic sel_ok;
  ctl_t ctl_q, ctl_d, wr_ctl;

  clk_src_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk      (clk),
    .arst_n_i (por_n),
    .rst_n_o  (por_sync_n)
  );

  clk_src_rst_sync #(.STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk      (clk),
    .arst_n_i (rst_n & por_n),
    .rst_n_o  (ctl_sync_n)
  );

  clk_src_startup #(.COUNT(AUX_COUNT)) u_aux (
    .clk      (clk),
    .arst_n_i (por_sync_n),
    .clr_i    (1'b0),
    .tick_i   (xtick_i),
    .rdy_o    (aux_rdy)
  );

  clk_src_startup #(.COUNT(MAIN_COUNT)) u_main (
    .clk      (clk),
    .arst_n_i (por_sync_n),
    .clr_i    (!ctl_q.en),
    .tick_i   (mtick_i),
    .rdy_o    (main_rdy)
  );

  assign wr_ctl = ctl_t'(wdata_i);
  assign sel_ok = (wr_ctl.sel == SEL_AUX) ? aux_rdy : main_rdy;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d.en  = wr_ctl.en;
      ctl_d.opt = wr_ctl.opt;
      if (sel_ok) ctl_d.sel = wr_ctl.sel;
    end
  end

  always_ff @(posedge clk or negedge ctl_sync_n) begin
    if (!ctl_sync_n) ctl_q <= CTL_RST;
    else             ctl_q <= ctl_d;
  end

  assign rdata_o   = {main_rdy, aux_rdy, 2'b00, ctl_q};
  assign osc_en_o  = ctl_q.en;
  assign clk_sel_o = ctl_q.sel;

endmodule

// File: rtl/clk_src_ctl_chk.sv
module clk_src_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic       wr_en_i,
  input logic [3:0] wdata_i,
  input logic       xtick_i,
  input logic       mtick_i,
  input logic [7:0] rdata_o,
  input logic       osc_en_o,
  input logic [1:0] clk_sel_o
);

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
    rdata_o[5:4] == 2'b00);

  assert_aux_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
    rdata_o[6] |=> rdata_o[6]);

  assert_aux_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rdata_o[6]) |-> $past(xtick_i));

  assert_main_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rdata_o[7]) |-> $past(mtick_i && osc_en_o));

  assert_main_drop_when_off_R6: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en_o |=> !rdata_o[7]);

  assert_aux_refused_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wr_en_i && wdata_i[3:2] == 2'b11 && !rdata_o[6]) |=> $stable(clk_sel_o));

  assert_main_refused_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wr_en_i && wdata_i[3:2] != 2'b11 && !rdata_o[7]) |=> $stable(clk_sel_o));

endmodule

bind clk_src_ctl clk_src_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_n     (por_n),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .xtick_i   (xtick_i),
  .mtick_i   (mtick_i),
  .rdata_o   (rdata_o),
  .osc_en_o  (osc_en_o),
  .clk_sel_o (clk_sel_o)
);

// File: tb/clk_src_ctl_tb.sv
module clk_src_ctl_tb;

  localparam int AUX_N  = 8072;
  localparam int MAIN_N = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wdata_i = 4'h0;
  logic       xtick_i = 1'b0;
  logic       mtick_i = 1'b0;
  logic [7:0] rdata_o;
  logic       osc_en_o;
  logic [1:0] clk_sel_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  int m_sel = 2, m_en = 1, m_opt = 0;
  int m_arpt = 0, m_mrdy = 0, m_acnt = 0, m_mcnt = 0;
  int m_pc = 0, m_rc = 0;

  clk_src_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .xtick_i(xtick_i), .mtick_i(mtick_i),
    .rdata_o(rdata_o), .osc_en_o(osc_en_o), .clk_sel_o(clk_sel_o)
  );

  always #5 clk = ~clk;

  function automatic int exp_rdata();
    return (m_mrdy << 7) | (m_arpt << 6) | (m_sel << 2) | (m_en << 1) | m_opt;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // reference model step plus per-cycle comparison
  always @(posedge clk) begin
    int por_hold, rst_hold;
    int n_sel, n_en, n_opt, n_arpt, n_mrdy, n_acnt, n_mcnt;
    int wsel;
    por_hold = (m_pc < 2);
    rst_hold = (m_rc < 2);
    m_pc = !por_n ? 0 : (m_pc < 2 ? m_pc + 1 : m_pc);
    m_rc = (!por_n || !rst_n) ? 0 : (m_rc < 2 ? m_rc + 1 : m_rc);
    if (!por_n) por_hold = 1;
    if (!por_n || !rst_n) rst_hold = 1;
    n_sel = m_sel; n_en = m_en; n_opt = m_opt;
    n_arpt = m_arpt; n_mrdy = m_mrdy; n_acnt = m_acnt; n_mcnt = m_mcnt;
    if (por_hold) begin
      n_arpt = 0; n_mrdy = 0; n_acnt = 0; n_mcnt = 0;
    end else begin
      if (xtick_i && !m_arpt) begin
        n_acnt = m_acnt + 1;
        if (n_acnt == AUX_N) n_arpt = 1;
      end
      if (!m_en) begin
        n_mcnt = 0; n_mrdy = 0;
      end else if (mtick_i && !m_mrdy) begin
        n_mcnt = m_mcnt + 1;
        if (n_mcnt == MAIN_N) n_mrdy = 1;
      end
    end
    if (rst_hold) begin
      n_sel = 2; n_en = 1; n_opt = 0;
    end else if (wr_en_i) begin
      wsel  = int'(wdata_i[3:2]);
      n_en  = int'(wdata_i[1]);
      n_opt = int'(wdata_i[0]);
      if ((wsel == 3) ? m_arpt : m_mrdy) n_sel = wsel;
    end
    m_sel = n_sel; m_en = n_en; m_opt = n_opt;
    m_arpt = n_arpt; m_mrdy = n_mrdy; m_acnt = n_acnt; m_mcnt = n_mcnt;
    #2;
    check("R1/R2/R3/R4/R5/R6/R7/R8/R9 rdata", int'(rdata_o), exp_rdata());
    check("R9 clk_sel_o", int'(clk_sel_o), m_sel);
    check("R9 osc_en_o", int'(osc_en_o), m_en);
    cycles++;
    if (cycles > 120000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk);
    wr_en_i = 1'b1;
    wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    idle(4);
    por_n = 1'b1;
    rst_n = 1'b1;
    idle(4);
    // R1 reset values
    check("R1 reset rdata", int'(rdata_o), 8'h0A);
    check("R1 reset clk_sel_o", int'(clk_sel_o), 2);
    // R8 refused selects before any oscillator is ready
    wr(4'b1110);
    check("R8 aux refused", int'(clk_sel_o), 2);
    wr(4'b0011);
    check("R8 main refused", int'(clk_sel_o), 2);
    check("R9 opt written on refused write", int'(rdata_o[0]), 1);
    // R5 main startup: one tick per cycle; R4 aux: one tick every third cycle
    for (int i = 0; i < 3 * AUX_N + 10; i++) begin
      @(negedge clk);
      mtick_i = 1'b1;
      xtick_i = (i % 3 == 0);
      if (i == MAIN_N - 2) begin
        @(posedge clk); #2;
        check("R5 main not early", int'(rdata_o[7]), 0);
      end
      if (i == MAIN_N - 1) begin
        @(posedge clk); #2;
        check("R5 main set", int'(rdata_o[7]), 1);
      end
    end
    mtick_i = 1'b0;
    xtick_i = 1'b0;
    check("R4 aux set", int'(rdata_o[6]), 1);
    // R8 accepted selects
    wr(4'b0010);
    check("R8 main accepted", int'(clk_sel_o), 0);
    wr(4'b1110);
    check("R8 aux accepted", int'(clk_sel_o), 3);
    // R7 flags read-only, reserved zero
    wr(4'b1111);
    check("R7 reserved/flags", int'(rdata_o[7:4]), 4'hC);
    // R6 disable main oscillator
    wr(4'b1100);
    idle(1);
    check("R6 main flag dropped", int'(rdata_o[7]), 0);
    wr(4'b1010);
    check("R8 main refused after drop", int'(clk_sel_o), 3);
    // R6 re-enable; sparse ticks restart from zero
    for (int i = 0; i < 2 * MAIN_N + 4; i++) begin
      @(negedge clk);
      mtick_i = (i % 2 == 1);
    end
    mtick_i = 1'b0;
    check("R6 main ready again", int'(rdata_o[7]), 1);
    // R3 ordinary reset keeps flags
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    check("R3 flags kept in reset", int'(rdata_o), 8'hCA);
    rst_n = 1'b1;
    idle(4);
    check("R3 flags kept after reset", int'(rdata_o[7:6]), 3);
    // R2 power-on clears flags
    @(negedge clk);
    por_n = 1'b0;
    idle(3);
    check("R2 flags cleared", int'(rdata_o), 8'h0A);
    por_n = 1'b1;
    idle(6);
    finish_run();
  end

endmodule